// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a small 32-bit processor core through the entry into an exception handler. Four causes can request entry: a non-maskable interrupt, a bus fault reported by the address translator, a software break instruction, and an external interrupt. Each request is a single-cycle pulse. The sequencer accepts one cause per entry and chooses the vector that belongs to it. It computes the return address, pulling that address back by the delay-slot count when the core was part way through a branch. It then reads the handler address from a vector table in memory.

When the table read returns, every special-register update is presented in one cycle, alongside a one-cycle `done` strobe:

- the return register the cause selects;
- the status word that carries the vector index;
- the stack-pointer exchange when the core was in user mode;
- the nested condition-code word.

The core writes these values into its own register file on that cycle. Instruction decode, address translation and interrupt arbitration all happen outside this block.

Top module: `exc_entry_seq`

## Requirements
- R1: An entry is accepted only while `busy` is low and `double_fault` is low. At most one cause is taken, in the priority order NMI, bus fault, break, external interrupt. `busy` is high from the cycle after acceptance until the cycle after the `done` pulse.
- R2: The vector is `brk_vec` for a break, `bf_vec` for a bus fault, `irq_vec` for an external interrupt, and 0 for an NMI.
- R3: For break, bus fault and interrupt, `erp_we` pulses with `done` and `erp_val` equals `cur_pc` minus `dslot_cnt` (32-bit wraparound). For an NMI, `nrp_we` pulses with `done`, `nrp_val` equals `cur_pc` unchanged, and `erp_we` stays low.
- R4: `exs_val` holds the low 8 bits of the vector in bits 15:8, and all its other bits are zero.
- R5: `mem_req` rises two cycles after acceptance. `mem_addr` equals `base_addr + vector*4` (32-bit wraparound). Both stay steady until `mem_valid` is seen. On the following cycle `new_pc` equals the `mem_rdata` that was captured.
- R6: If bit `U_BIT` (default 8) of `cur_ccs` was set at acceptance, `stk_swap` pulses with `done`, `usp_val` equals `cur_sp` and `sp_val` equals `ksp_saved`. Otherwise `stk_swap` stays low.
- R7: `ccs_val` equals `((c & 0xC0000000) | ((c << 12) >> 2)) & ~0x3FF`, using 32-bit logical shifts. Here `c` is `cur_ccs`, with bit `M_BIT` (default 9) cleared first when the cause is an NMI.
- R8: `done` lasts exactly one cycle. It comes in the cycle after `mem_valid` is seen. `dslot_clr` pulses with `done` only when the latched delay-slot count is nonzero.
- R9: A bus-fault request during a bus-fault entry sets `double_fault`. It stays set until reset, and from then on no new entry is accepted.
- R10: Requests that arrive while `busy` is high, other than the case in R9, have no effect on the running entry or on later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_nmi | input | 1 | Non-maskable interrupt request pulse |
| req_bfault | input | 1 | Bus-fault request pulse |
| req_brk | input | 1 | Software break request pulse |
| req_irq | input | 1 | External interrupt request pulse |
| brk_vec | input | VEC_W | Vector of the break trap |
| bf_vec | input | VEC_W | Vector reported with the bus fault |
| irq_vec | input | VEC_W | Vector from the interrupt controller |
| cur_pc | input | 32 | Program counter at the moment of the request |
| cur_sp | input | 32 | Current stack pointer |
| cur_ccs | input | 32 | Current condition-code word |
| base_addr | input | 32 | Vector-table base address |
| ksp_saved | input | 32 | Saved kernel stack pointer |
| dslot_cnt | input | DS_W | Delay-slot byte count, 0 when not in a slot |
| mem_req | output | 1 | Vector-table read request |
| mem_addr | output | 32 | Vector-table read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Commit strobe |
| new_pc | output | 32 | Handler address |
| erp_we | output | 1 | Write the exception return register |
| erp_val | output | 32 | Exception return value |
| nrp_we | output | 1 | Write the NMI return register |
| nrp_val | output | 32 | NMI return value |
| exs_val | output | 32 | Exception-status word, written on `done` |
| stk_swap | output | 1 | Perform the stack-pointer exchange |
| usp_val | output | 32 | Value for the user stack pointer register |
| sp_val | output | 32 | New stack pointer |
| ccs_val | output | 32 | New condition-code word, written on `done` |
| dslot_clr | output | 1 | Clear the core's delay-slot state |
| double_fault | output | 1 | Sticky fatal nested bus fault |

## Verification
The bench builds the block with its defaults: an 8-bit vector, a 2-bit delay-slot count, U at bit 8 and M at bit 9. The 8-bit vector allows vector 255, which is the top table entry, and a table base near the top of the address space, so the address sum wraps. The 2-bit count allows rollbacks of up to 3 bytes, including a wrap below zero. With M at bit 9 and U at bit 8, both flags fall inside the ten bits that the shift clears, and M also lands at bit 19 after the shift. Together these values show whether the NMI clears the flag before the shift or after it.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int VEC_W = 8,
  parameter int DS_W  = 2,
  parameter int U_BIT = 8,
  parameter int M_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_nmi,
  input  logic             req_bfault,
  input  logic             req_brk,
  input  logic             req_irq,
  input  logic [VEC_W-1:0] brk_vec,
  input  logic [VEC_W-1:0] bf_vec,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [31:0]      cur_pc,
  input  logic [31:0]      cur_sp,
  input  logic [31:0]      cur_ccs,
  input  logic [31:0]      base_addr,
  input  logic [31:0]      ksp_saved,
  input  logic [DS_W-1:0]  dslot_cnt,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_valid,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [31:0]      new_pc,
  output logic             erp_we,
  output logic [31:0]      erp_val,
  output logic             nrp_we,
  output logic [31:0]      nrp_val,
  output logic [31:0]      exs_val,
  output logic             stk_swap,
  output logic [31:0]      usp_val,
  output logic [31:0]      sp_val,
  output logic [31:0]      ccs_val,
  output logic             dslot_clr,
  output logic             double_fault
);

  localparam logic [31:0] KEEP_TOP = 32'hC000_0000;
  localparam logic [31:0] LOW_MASK = 32'h0000_03FF;

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_FETCH, ST_COMMIT} st_t;

  st_t             st;
  logic            nmi_q, bf_q, user_q;
  logic [VEC_W-1:0] vec_q;
  logic [31:0]     pc_q, sp_q, ksp_q, ccs_q, ebp_q;
  logic [31:0]     addr_q, ret_q, ccs_new_q, pc_new_q;
  logic [DS_W-1:0] ds_q;
  logic            fatal_q;

  logic            any_req, accept;
  logic [VEC_W-1:0] vec_sel;
  logic [31:0]     vec_ext, ccs_pre;

  assign any_req = req_nmi | req_bfault | req_brk | req_irq;
  assign accept  = (st == ST_IDLE) && !fatal_q && any_req;

  always_comb begin
    if (req_nmi)         vec_sel = '0;
    else if (req_bfault) vec_sel = bf_vec;
    else if (req_brk)    vec_sel = brk_vec;
    else                 vec_sel = irq_vec;
  end

  assign vec_ext = 32'(vec_q);

  always_comb begin
    ccs_pre = ccs_q;
    if (nmi_q) ccs_pre[M_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      nmi_q <= 1'b0; bf_q <= 1'b0; user_q <= 1'b0;
      vec_q <= '0; ds_q <= '0;
      pc_q <= '0; sp_q <= '0; ksp_q <= '0; ccs_q <= '0; ebp_q <= '0;
      addr_q <= '0; ret_q <= '0; ccs_new_q <= '0; pc_new_q <= '0;
      fatal_q <= 1'b0;
    end else begin
      if (st != ST_IDLE && bf_q && req_bfault) fatal_q <= 1'b1;
      case (st)
        ST_IDLE: if (accept) begin
          nmi_q  <= req_nmi;
          bf_q   <= !req_nmi && req_bfault;
          vec_q  <= vec_sel;
          pc_q   <= cur_pc;
          sp_q   <= cur_sp;
          ksp_q  <= ksp_saved;
          ccs_q  <= cur_ccs;
          user_q <= cur_ccs[U_BIT];
          ebp_q  <= base_addr;
          ds_q   <= dslot_cnt;
          st     <= ST_SAVE;
        end
        ST_SAVE: begin
          addr_q    <= ebp_q + {vec_ext[29:0], 2'b00};
          ret_q     <= pc_q - 32'(ds_q);
          ccs_new_q <= ((ccs_pre & KEEP_TOP) | ((ccs_pre << 12) >> 2)) & ~LOW_MASK;
          st        <= ST_FETCH;
        end
        ST_FETCH: if (mem_valid) begin
          pc_new_q <= mem_rdata;
          st       <= ST_COMMIT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (st != ST_IDLE);
  assign done         = (st == ST_COMMIT);
  assign mem_req      = (st == ST_FETCH);
  assign mem_addr     = addr_q;
  assign new_pc       = pc_new_q;
  assign erp_we       = done && !nmi_q;
  assign erp_val      = ret_q;
  assign nrp_we       = done && nmi_q;
  assign nrp_val      = pc_q;
  assign exs_val      = {16'h0000, vec_ext[7:0], 8'h00};
  assign stk_swap     = done && user_q;
  assign usp_val      = sp_q;
  assign sp_val       = ksp_q;
  assign ccs_val      = ccs_new_q;
  assign dslot_clr    = done && (ds_q != '0);
  assign double_fault = fatal_q;

  // R3
  ret_reg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(erp_we && nrp_we));

  // R4
  exs_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (exs_val[7:0] == 8'h00 && exs_val[31:16] == 16'h0000));

  // R7
  ccs_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ccs_val[9:0] == 10'h000));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    double_fault |=> double_fault);

  // R1
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!double_fault));

endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_nmi = 0, req_bfault = 0, req_brk = 0, req_irq = 0;
  logic [7:0] brk_vec = 0, bf_vec = 0, irq_vec = 0;
  logic [31:0] cur_pc = 0, cur_sp = 0, cur_ccs = 0, base_addr = 0, ksp_saved = 0;
  logic [1:0] dslot_cnt = 0;
  logic mem_req, mem_valid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic busy, done, erp_we, nrp_we, stk_swap, dslot_clr, double_fault;
  logic [31:0] new_pc, erp_val, nrp_val, exs_val, usp_val, sp_val, ccs_val;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ccs_model(input logic [31:0] c, input bit nmi);
    logic [31:0] m;
    m = c;
    if (nmi) m[9] = 1'b0;
    return ((m & 32'hC000_0000) | ((m << 12) >> 2)) & ~32'h3FF;
  endfunction

  // Drives one entry; req = {nmi,bf,brk,irq}; inj pulsed while busy.
  task automatic run_entry(input logic [3:0] req, input logic [3:0] inj,
                           input logic [7:0] vb, input logic [7:0] vf, input logic [7:0] vi,
                           input logic [31:0] pc, input logic [31:0] sp, input logic [31:0] ccs,
                           input logic [31:0] ebp, input logic [31:0] ksp, input logic [1:0] ds,
                           input int lat, input string name);
    logic [7:0] ev; bit nmi; logic [31:0] ea, rd; int n;
    nmi = req[3];
    ev = req[3] ? 8'd0 : req[2] ? vf : req[1] ? vb : vi;
    ea = ebp + {22'd0, ev, 2'b00};
    rd = ea ^ 32'h5A5A_0F0F;
    @(negedge clk);
    {req_nmi, req_bfault, req_brk, req_irq} = req;
    brk_vec = vb; bf_vec = vf; irq_vec = vi;
    cur_pc = pc; cur_sp = sp; cur_ccs = ccs; base_addr = ebp; ksp_saved = ksp; dslot_cnt = ds;
    @(negedge clk);
    {req_nmi, req_bfault, req_brk, req_irq} = inj;
    cur_pc = 32'hDEAD_BEEF; cur_ccs = 32'hFFFF_FFFF; brk_vec = 8'h77; irq_vec = 8'h66; bf_vec = 8'h55;
    chk(busy === 1'b1, {"R1 busy after accept ", name}, 32'(busy), 1);
    @(negedge clk);
    {req_nmi, req_bfault, req_brk, req_irq} = 4'b0000;
    chk(mem_req === 1'b1, {"R5 mem_req timing ", name}, 32'(mem_req), 1);
    chk(mem_addr === ea, {"R2 R5 table address ", name}, mem_addr, ea);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(mem_req === 1'b1 && mem_addr === ea && !done, {"R5 request held ", name}, mem_addr, ea);
    end
    mem_valid = 1'b1; mem_rdata = rd;
    @(negedge clk);
    mem_valid = 1'b0; mem_rdata = 32'h0;
    n = 0;
    chk(done === 1'b1, {"R8 done after valid ", name}, 32'(done), 1);
    chk(new_pc === rd, {"R5 new_pc ", name}, new_pc, rd);
    chk(exs_val === {16'h0, ev, 8'h0}, {"R4 exs ", name}, exs_val, {16'h0, ev, 8'h0});
    chk(ccs_val === ccs_model(ccs, nmi), {"R7 ccs ", name}, ccs_val, ccs_model(ccs, nmi));
    if (nmi) begin
      chk(nrp_we === 1'b1 && erp_we === 1'b0, {"R3 nmi strobes ", name}, {30'd0, nrp_we, erp_we}, 32'd2);
      chk(nrp_val === pc, {"R3 nrp value ", name}, nrp_val, pc);
    end else begin
      chk(erp_we === 1'b1 && nrp_we === 1'b0, {"R3 erp strobes ", name}, {30'd0, nrp_we, erp_we}, 32'd1);
      chk(erp_val === pc - 32'(ds), {"R3 erp rollback ", name}, erp_val, pc - 32'(ds));
    end
    chk(stk_swap === ccs[8], {"R6 swap strobe ", name}, 32'(stk_swap), 32'(ccs[8]));
    if (ccs[8]) chk(usp_val === sp && sp_val === ksp, {"R6 swap values ", name}, sp_val, ksp);
    chk(dslot_clr === (ds != 0), {"R8 dslot_clr ", name}, 32'(dslot_clr), 32'(ds != 0));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, {"R8 R10 back to idle ", name},
        {29'd0, done, busy, mem_req}, 0);
    @(negedge clk);
    chk(busy === 1'b0, {"R10 no late entry ", name}, 32'(busy), 0);
  endtask

  task automatic t_reset();
    chk(busy === 0 && done === 0 && mem_req === 0 && double_fault === 0 &&
        erp_we === 0 && nrp_we === 0, "R1 R8 reset state", {28'd0, busy, done, mem_req, double_fault}, 0);
  endtask

  task automatic t_fatal();
    run_entry(4'b0100, 4'b0100, 8'h01, 8'h0A, 8'h02, 32'h0000_4000, 32'h10, 32'h0, 32'h0000_2000, 32'h20, 2'd0, 0, "double fault");
    chk(double_fault === 1'b1, "R9 double fault set", 32'(double_fault), 1);
    @(negedge clk); req_brk = 1'b1;
    @(negedge clk); req_brk = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(busy === 0 && mem_req === 0 && double_fault === 1, "R9 entry blocked after fatal",
          {30'd0, busy, mem_req}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_entry(4'b0010, 4'b0000, 8'h12, 8'h00, 8'h00, 32'h0000_1000, 32'h100, 32'h0000_0012, 32'h0008_0000, 32'h200, 2'd0, 0, "break");
    run_entry(4'b0001, 4'b0000, 8'h00, 8'h00, 8'hFF, 32'h8000_0040, 32'hAAAA_0000, 32'hC000_0155, 32'hFFFF_FE00, 32'h5555_0000, 2'd0, 3, "irq user wrap");
    run_entry(4'b0100, 4'b0000, 8'h00, 8'h3C, 8'h00, 32'h0000_2002, 32'h300, 32'h0000_0100, 32'h0010_0000, 32'h400, 2'd2, 1, "bus fault slot");
    run_entry(4'b1000, 4'b0000, 8'h21, 8'h22, 8'h23, 32'h0000_5000, 32'h500, 32'h4008_0300, 32'h0020_0000, 32'h600, 2'd1, 0, "nmi");
    run_entry(4'b1111, 4'b0000, 8'h31, 8'h32, 8'h33, 32'h0000_6000, 32'h700, 32'h0000_0000, 32'h0030_0000, 32'h800, 2'd0, 0, "all four");
    run_entry(4'b0111, 4'b0000, 8'h41, 8'h42, 8'h43, 32'h0000_7000, 32'h900, 32'h0000_0000, 32'h0040_0000, 32'hA00, 2'd0, 0, "bf brk irq");
    run_entry(4'b0011, 4'b1011, 8'h51, 8'h52, 8'h53, 32'h0000_0001, 32'hB00, 32'h0000_0000, 32'h0050_0000, 32'hC00, 2'd3, 2, "brk irq ignored");
    t_fatal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(400_000ns);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule